// File: doc/BRIEF.md
# Three-Phase Accumulator Processor Core

This core is a small load/store processor with separate instruction and data memories. All computation happens in two 32-bit working registers, A and B. Two 1-bit flags record the outcome of the last arithmetic or logic operation: C holds the carry or borrow, and Z is set when that result was zero. The core has no pipeline. A sequencer steps through three phases for every instruction: first the instruction is captured, then the program counter advances while the data memory is prepared, and finally the instruction is decoded and executed. Memory, arithmetic and branch instructions alike take exactly three enabled clocks.

The instruction memory is read asynchronously at `imem_addr`, and its word is captured into the instruction register. The data memory is a 256 x 32-bit synchronous RAM. A read is requested in the second phase and its data must be held on `dmem_rdata` until the next read request; the core captures that data at the end of the third phase. A write is presented in the second and third phases with the same address and data. Both memory ports have fixed timing: they carry no valid/ready handshake and exert no back-pressure. The only way to stall the core is to drop `en`. Debug outputs show the architectural state at all times.

Instruction word layout: [31:28] class, [27:24] sub-operation, [23:16] ignored, [15:0] constant or address. An operand written as "k" below is IR[15:0] zero-extended to 32 bits.

Top module: `tri_phase_cpu`

## Requirements
- R1: A synchronous active-high `rst` clears PC, IR, A, B, C and Z to zero and returns the sequencer to the capture phase.
- R2: While `en` is high, the phase sequence runs capture -> advance -> execute and then repeats. `imem_addr` always equals PC. IR takes the word at PC at the end of the capture phase. PC increments by 1, wrapping within 64 words, at the end of the advance phase.
- R3: While `en` is low, PC, IR, A, B, C, Z and the phase all hold their values, and `dmem_re` and `dmem_we` are low.
- R4: Decoding uses only IR[31:28] and IR[27:24], with IR[15:0] as the operand. Bits [23:16] have no effect.
- R5: Class 1 instructions are: sub 0 SETA (A<=k), sub 1 SETB (B<=k), sub 2 SETHI (A<={IR[15:0],16'h0}), sub 3 ZEROA (A<=0) and sub 4 ZEROB (B<=0). None of them changes a flag.
- R6: Class 0 sub 0 LOADA and sub 1 LOADB assert `dmem_re` during the advance phase only, with `dmem_addr`=IR[7:0]. A or B takes `dmem_rdata` at the end of the execute phase.
- R7: Class 0 sub 2 STOREA and sub 3 STOREB assert `dmem_we` in both the advance and execute phases, with `dmem_addr`=IR[7:0] and `dmem_wdata` equal to A or B respectively.
- R8: Class 7 sub-operations 0 ADD (A+B), 1 SUB (A-B), 2 ANDK (A&k), 3 ORK (A|k) and 4 ADDK (A+k) write their result to A. C receives the carry-out for additions, the borrow (A<operand) for SUB, and 0 for the logic operations. Z is set when the result is zero.
- R9: Class 7 sub 5 INC (A+1, C=carry-out) and sub 6 DEC (A-1, C=borrow) write A. So do sub 7 ROL (rotate left one bit, C=old A[31]) and sub 8 ROR (rotate right one bit, C=old A[0]). All four set Z when the result is zero.
- R10: Class 2 instructions are: sub 0 JUMP (always taken), sub 1 BRZ (taken when Z=1) and sub 2 BRNZ (taken when Z=0). A taken branch loads PC with IR[5:0] at the end of the execute phase.
- R11: Any other class or sub-operation value is a no-op. Only PC advances, and no memory strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the core |
| imem_addr | output | 6 | Instruction word address (PC) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data word address |
| dmem_re | output | 1 | Data read request |
| dmem_we | output | 1 | Data write enable |
| dmem_wdata | output | 32 | Data to write |
| dmem_rdata | input | 32 | Registered read data |
| dbg_pc | output | 6 | Program counter |
| dbg_ir | output | 32 | Instruction register |
| dbg_a | output | 32 | Working register A |
| dbg_b | output | 32 | Working register B |
| dbg_c | output | 1 | Carry/borrow flag |
| dbg_z | output | 1 | Zero flag |

## Verification
A directed program runs first. It drives A to all-ones and then increments it to zero, so the carry and zero flags are set together. It takes one taken branch of each polarity and makes a store/clear/load round trip through one data word. It also feeds an immediate load with junk in the ignored bits, which shows whether decoding leaks outside the class and sub fields. After that, thousands of random words are executed, covering every class, listed and unlisted sub-operations, and random branch targets. Enable gaps of random length are inserted inside the phases; they separate a correct freeze from a phase that slips or a memory strobe that repeats. After every instruction, a bench instruction model is compared with all debug outputs, the strobe timing in each phase and the written memory word.

// File: rtl/tri_phase_cpu_pkg.sv
package tri_phase_cpu_pkg;

  typedef enum logic [1:0] {
    PH_CAPTURE = 2'd0,
    PH_ADVANCE = 2'd1,
    PH_EXECUTE = 2'd2
  } phase_e;

  localparam logic [3:0] CLS_MEM  = 4'h0;
  localparam logic [3:0] CLS_SET  = 4'h1;
  localparam logic [3:0] CLS_FLOW = 4'h2;
  localparam logic [3:0] CLS_ALU  = 4'h7;

  localparam logic [3:0] SUB_LOADA  = 4'h0;
  localparam logic [3:0] SUB_LOADB  = 4'h1;
  localparam logic [3:0] SUB_STOREA = 4'h2;
  localparam logic [3:0] SUB_STOREB = 4'h3;

  localparam logic [3:0] SUB_SETA  = 4'h0;
  localparam logic [3:0] SUB_SETB  = 4'h1;
  localparam logic [3:0] SUB_SETHI = 4'h2;
  localparam logic [3:0] SUB_ZEROA = 4'h3;
  localparam logic [3:0] SUB_ZEROB = 4'h4;

  localparam logic [3:0] SUB_JUMP = 4'h0;
  localparam logic [3:0] SUB_BRZ  = 4'h1;
  localparam logic [3:0] SUB_BRNZ = 4'h2;

  localparam logic [3:0] SUB_ADD  = 4'h0;
  localparam logic [3:0] SUB_SUB  = 4'h1;
  localparam logic [3:0] SUB_ANDK = 4'h2;
  localparam logic [3:0] SUB_ORK  = 4'h3;
  localparam logic [3:0] SUB_ADDK = 4'h4;
  localparam logic [3:0] SUB_INC  = 4'h5;
  localparam logic [3:0] SUB_DEC  = 4'h6;
  localparam logic [3:0] SUB_ROL  = 4'h7;
  localparam logic [3:0] SUB_ROR  = 4'h8;

  typedef enum logic [2:0] {
    AOP_ADD, AOP_SUB, AOP_AND, AOP_OR, AOP_ROL, AOP_ROR
  } alu_op_e;

  typedef enum logic [1:0] {
    OPND_REG_B, OPND_CONST, OPND_ONE
  } opnd_e;

  typedef struct packed {
    logic    load_a;
    logic    load_b;
    logic    store_a;
    logic    store_b;
    logic    set_a;
    logic    set_b;
    logic    set_hi;
    logic    zero_a;
    logic    zero_b;
    logic    jump;
    logic    br_z;
    logic    br_nz;
    logic    alu_en;
    alu_op_e alu_op;
    opnd_e   opnd;
  } ctl_t;

endpackage

// File: rtl/tri_phase_seq.sv
module tri_phase_seq
  import tri_phase_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  output phase_e phase
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_CAPTURE;
    end else if (en) begin
      case (phase)
        PH_CAPTURE: phase <= PH_ADVANCE;
        PH_ADVANCE: phase <= PH_EXECUTE;
        default:    phase <= PH_CAPTURE;
      endcase
    end
  end

  // R2: phase order while enabled
  a_r2_capture_next: assert property (@(posedge clk) disable iff (rst)
    en && phase == PH_CAPTURE |=> phase == PH_ADVANCE);
  a_r2_advance_next: assert property (@(posedge clk) disable iff (rst)
    en && phase == PH_ADVANCE |=> phase == PH_EXECUTE);
  a_r2_execute_next: assert property (@(posedge clk) disable iff (rst)
    en && phase == PH_EXECUTE |=> phase == PH_CAPTURE);
  // R3: phase frozen while disabled
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase));

endmodule

// File: rtl/tri_phase_dec.sv
module tri_phase_dec
  import tri_phase_cpu_pkg::*;
(
  input  logic [3:0] cls,
  input  logic [3:0] sub,
  output ctl_t       ctl
);

  always_comb begin
    ctl        = '0;
    ctl.alu_op = AOP_ADD;
    ctl.opnd   = OPND_REG_B;
    case (cls)
      CLS_MEM: begin
        case (sub)
          SUB_LOADA:  ctl.load_a  = 1'b1;
          SUB_LOADB:  ctl.load_b  = 1'b1;
          SUB_STOREA: ctl.store_a = 1'b1;
          SUB_STOREB: ctl.store_b = 1'b1;
          default: ;
        endcase
      end
      CLS_SET: begin
        case (sub)
          SUB_SETA:  ctl.set_a  = 1'b1;
          SUB_SETB:  ctl.set_b  = 1'b1;
          SUB_SETHI: ctl.set_hi = 1'b1;
          SUB_ZEROA: ctl.zero_a = 1'b1;
          SUB_ZEROB: ctl.zero_b = 1'b1;
          default: ;
        endcase
      end
      CLS_FLOW: begin
        case (sub)
          SUB_JUMP: ctl.jump  = 1'b1;
          SUB_BRZ:  ctl.br_z  = 1'b1;
          SUB_BRNZ: ctl.br_nz = 1'b1;
          default: ;
        endcase
      end
      CLS_ALU: begin
        ctl.alu_en = 1'b1;
        case (sub)
          SUB_ADD:  begin ctl.alu_op = AOP_ADD; ctl.opnd = OPND_REG_B; end
          SUB_SUB:  begin ctl.alu_op = AOP_SUB; ctl.opnd = OPND_REG_B; end
          SUB_ANDK: begin ctl.alu_op = AOP_AND; ctl.opnd = OPND_CONST; end
          SUB_ORK:  begin ctl.alu_op = AOP_OR;  ctl.opnd = OPND_CONST; end
          SUB_ADDK: begin ctl.alu_op = AOP_ADD; ctl.opnd = OPND_CONST; end
          SUB_INC:  begin ctl.alu_op = AOP_ADD; ctl.opnd = OPND_ONE;   end
          SUB_DEC:  begin ctl.alu_op = AOP_SUB; ctl.opnd = OPND_ONE;   end
          SUB_ROL:  ctl.alu_op = AOP_ROL;
          SUB_ROR:  ctl.alu_op = AOP_ROR;
          default:  ctl.alu_en = 1'b0;
        endcase
      end
      default: ;
    endcase
  end

  // R11: at most one register-writing action per instruction
  always_comb begin
    a_r11_single_action: assert ($countones({ctl.load_a, ctl.load_b, ctl.store_a,
      ctl.store_b, ctl.set_a, ctl.set_b, ctl.set_hi, ctl.zero_a, ctl.zero_b,
      ctl.jump, ctl.br_z, ctl.br_nz, ctl.alu_en}) <= 1);
  end

endmodule

// File: rtl/tri_phase_alu.sv
module tri_phase_alu
  import tri_phase_cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res,
  output logic         cy
);

  logic [W:0] sum;
  logic [W:0] diff;

  assign sum  = {1'b0, x} + {1'b0, y};
  assign diff = {1'b0, x} - {1'b0, y};

  always_comb begin
    res = sum[W-1:0];
    cy  = sum[W];
    case (op)
      AOP_ADD: begin res = sum[W-1:0];  cy = sum[W];  end
      AOP_SUB: begin res = diff[W-1:0]; cy = diff[W]; end
      AOP_AND: begin res = x & y;       cy = 1'b0;    end
      AOP_OR:  begin res = x | y;       cy = 1'b0;    end
      AOP_ROL: begin res = {x[W-2:0], x[W-1]}; cy = x[W-1]; end
      AOP_ROR: begin res = {x[0], x[W-1:1]};   cy = x[0];   end
      default: ;
    endcase
  end

endmodule

// File: rtl/tri_phase_cpu.sv
module tri_phase_cpu
  import tri_phase_cpu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [IMEM_AW-1:0] imem_addr,
  input  logic [31:0]        imem_data,
  output logic [DMEM_AW-1:0] dmem_addr,
  output logic               dmem_re,
  output logic               dmem_we,
  output logic [DATA_W-1:0]  dmem_wdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  output logic [IMEM_AW-1:0] dbg_pc,
  output logic [31:0]        dbg_ir,
  output logic [DATA_W-1:0]  dbg_a,
  output logic [DATA_W-1:0]  dbg_b,
  output logic               dbg_c,
  output logic               dbg_z
);

  localparam int IMM_W = 16;
  localparam int EXT_W = DATA_W - IMM_W;
  localparam logic [IMEM_AW-1:0] PC_ONE = IMEM_AW'(1);
  localparam logic [DATA_W-1:0]  ONE_W  = DATA_W'(1);

  phase_e              phase;
  ctl_t                ctl;
  logic [IMEM_AW-1:0]  pc;
  logic [31:0]         ir;
  logic [DATA_W-1:0]   reg_a, reg_b;
  logic                flag_c, flag_z;
  logic [DATA_W-1:0]   konst, hi_konst, alu_y, alu_res;
  logic                alu_cy, take_br, mem_rd, mem_wr;

  tri_phase_seq i_seq (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .phase (phase)
  );

  tri_phase_dec i_dec (
    .cls (ir[31:28]),
    .sub (ir[27:24]),
    .ctl (ctl)
  );

  assign konst    = {{EXT_W{1'b0}}, ir[IMM_W-1:0]};
  assign hi_konst = {ir[IMM_W-1:0], {EXT_W{1'b0}}};

  always_comb begin
    case (ctl.opnd)
      OPND_CONST: alu_y = konst;
      OPND_ONE:   alu_y = ONE_W;
      default:    alu_y = reg_b;
    endcase
  end

  tri_phase_alu #(.W(DATA_W)) i_alu (
    .op  (ctl.alu_op),
    .x   (reg_a),
    .y   (alu_y),
    .res (alu_res),
    .cy  (alu_cy)
  );

  assign mem_rd  = ctl.load_a | ctl.load_b;
  assign mem_wr  = ctl.store_a | ctl.store_b;
  assign take_br = ctl.jump | (ctl.br_z & flag_z) | (ctl.br_nz & ~flag_z);

  assign imem_addr  = pc;
  assign dmem_addr  = ir[DMEM_AW-1:0];
  assign dmem_re    = en & mem_rd & (phase == PH_ADVANCE);
  assign dmem_we    = en & mem_wr & (phase != PH_CAPTURE);
  assign dmem_wdata = ctl.store_b ? reg_b : reg_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      ir     <= '0;
      reg_a  <= '0;
      reg_b  <= '0;
      flag_c <= 1'b0;
      flag_z <= 1'b0;
    end else if (en) begin
      case (phase)
        PH_CAPTURE: ir <= imem_data;
        PH_ADVANCE: pc <= pc + PC_ONE;
        PH_EXECUTE: begin
          if (ctl.load_a) reg_a <= dmem_rdata;
          if (ctl.load_b) reg_b <= dmem_rdata;
          if (ctl.set_a)  reg_a <= konst;
          if (ctl.set_b)  reg_b <= konst;
          if (ctl.set_hi) reg_a <= hi_konst;
          if (ctl.zero_a) reg_a <= '0;
          if (ctl.zero_b) reg_b <= '0;
          if (ctl.alu_en) begin
            reg_a  <= alu_res;
            flag_c <= alu_cy;
            flag_z <= (alu_res == '0);
          end
          if (take_br) pc <= ir[IMEM_AW-1:0];
        end
        default: ;
      endcase
    end
  end

  assign dbg_pc = pc;
  assign dbg_ir = ir;
  assign dbg_a  = reg_a;
  assign dbg_b  = reg_b;
  assign dbg_c  = flag_c;
  assign dbg_z  = flag_z;

  // R3: architectural state frozen while disabled
  a_r3_state_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc) && $stable(ir) && $stable(reg_a) && $stable(reg_b)
            && $stable(flag_c) && $stable(flag_z));
  // R2: PC steps by one after the advance phase
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    en && phase == PH_ADVANCE |=> pc == $past(pc) + PC_ONE);
  // R2: PC untouched during capture
  a_r2_pc_capture: assert property (@(posedge clk) disable iff (rst)
    phase == PH_CAPTURE |=> $stable(pc));
  // R6: read strobe only in the advance phase
  a_r6_read_phase: assert property (@(posedge clk) disable iff (rst)
    dmem_re |-> phase == PH_ADVANCE);
  // R7: write strobe never in the capture phase
  a_r7_write_phase: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> phase != PH_CAPTURE);
  // R8: zero flag agrees with A after an ALU execute
  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    en && phase == PH_EXECUTE && ctl.alu_en |=> flag_z == (reg_a == '0));

endmodule

// File: tb/test_tri_phase_cpu.sv
`timescale 1ns/1ps
module test_tri_phase_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [5:0]  imem_addr;
  logic [31:0] imem_data;
  logic [7:0]  dmem_addr;
  logic        dmem_re, dmem_we;
  logic [31:0] dmem_wdata;
  logic [31:0] dmem_rdata = '0;
  logic [5:0]  dbg_pc;
  logic [31:0] dbg_ir, dbg_a, dbg_b;
  logic        dbg_c, dbg_z;

  logic [31:0] imem  [64];
  logic [31:0] mem_d [256];
  logic [31:0] m_dmem[256];
  logic [5:0]  m_pc;
  logic [31:0] m_ir, m_a, m_b;
  logic        m_c, m_z;
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  tri_phase_cpu i_tri_phase_cpu (
    .clk(clk), .rst(rst), .en(en),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_re(dmem_re), .dmem_we(dmem_we),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_a(dbg_a), .dbg_b(dbg_b),
    .dbg_c(dbg_c), .dbg_z(dbg_z)
  );

  assign imem_data = imem[imem_addr];

  always @(posedge clk) begin
    if (dmem_we) mem_d[dmem_addr] <= dmem_wdata;
    if (dmem_re) dmem_rdata <= mem_d[dmem_addr];
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] s,
                                     input logic [15:0] k);
    return {c, s, 8'h00, k};
  endfunction

  function automatic string req_for(input logic [31:0] w);
    case (w[31:28])
      4'h0: return (w[27:24] < 2) ? "R6" : (w[27:24] < 4) ? "R7" : "R11";
      4'h1: return (w[27:24] < 5) ? "R5" : "R11";
      4'h2: return (w[27:24] < 3) ? "R10" : "R11";
      4'h7: return (w[27:24] < 5) ? "R8" : (w[27:24] < 9) ? "R9" : "R11";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_pc = '0; m_ir = '0; m_a = '0; m_b = '0; m_c = 1'b0; m_z = 1'b0;
  endtask

  task automatic model_exec();
    logic [3:0]  s;
    logic [31:0] k;
    logic [32:0] r;
    logic [7:0]  ad;
    m_ir = imem[m_pc];
    s  = m_ir[27:24];
    k  = {16'h0, m_ir[15:0]};
    ad = m_ir[7:0];
    m_pc = m_pc + 6'd1;
    case (m_ir[31:28])
      4'h0: case (s)
        4'd0: m_a = m_dmem[ad];
        4'd1: m_b = m_dmem[ad];
        4'd2: m_dmem[ad] = m_a;
        4'd3: m_dmem[ad] = m_b;
        default: ;
      endcase
      4'h1: case (s)
        4'd0: m_a = k;
        4'd1: m_b = k;
        4'd2: m_a = {m_ir[15:0], 16'h0};
        4'd3: m_a = '0;
        4'd4: m_b = '0;
        default: ;
      endcase
      4'h2: begin
        if (s == 0 || (s == 1 && m_z) || (s == 2 && !m_z)) m_pc = m_ir[5:0];
      end
      4'h7: begin
        if (s <= 8) begin
          case (s)
            4'd0: r = {1'b0, m_a} + {1'b0, m_b};
            4'd1: r = {1'b0, m_a} - {1'b0, m_b};
            4'd2: r = {1'b0, m_a & k};
            4'd3: r = {1'b0, m_a | k};
            4'd4: r = {1'b0, m_a} + {1'b0, k};
            4'd5: r = {1'b0, m_a} + 33'd1;
            4'd6: r = {1'b0, m_a} - 33'd1;
            4'd7: r = {m_a[31], m_a[30:0], m_a[31]};
            default: r = {m_a[0], m_a[0], m_a[31:1]};
          endcase
          m_a = r[31:0]; m_c = r[32]; m_z = (r[31:0] == 0);
        end
      end
      default: ;
    endcase
  endtask

  // R3: hold en low for a few cycles and confirm nothing moves
  task automatic gap();
    logic [5:0] p0; logic [31:0] i0, a0, b0; logic c0, z0; bit ok;
    int n;
    n = $urandom_range(1, 3);
    en = 1'b0; #1;
    p0 = dbg_pc; i0 = dbg_ir; a0 = dbg_a; b0 = dbg_b; c0 = dbg_c; z0 = dbg_z;
    ok = 1;
    for (int i = 0; i < n; i++) begin
      if (dmem_re || dmem_we) ok = 0;
      @(posedge clk); @(negedge clk);
    end
    ok = ok && dbg_pc == p0 && dbg_ir == i0 && dbg_a == a0 && dbg_b == b0
         && dbg_c == c0 && dbg_z == z0;
    check(ok, "R3", "frozen state", {dbg_pc, dbg_a[25:0]}, {p0, a0[25:0]});
  endtask

  task automatic step(input bit allow_gap);
    logic [31:0] w; bit ld, st, ctl_ok, ok; string rq;
    w  = imem[m_pc];
    ld = (w[31:28] == 4'h0) && (w[27:24] < 2);
    st = (w[31:28] == 4'h0) && (w[27:24] == 2 || w[27:24] == 3);
    ctl_ok = 1;
    for (int ph = 0; ph < 3; ph++) begin
      if (allow_gap && $urandom_range(0, 11) == 0) gap();
      en = 1'b1; #1;
      if (dmem_re !== (ld && ph == 1) || dmem_we !== (st && ph > 0)) ctl_ok = 0;
      if ((ld || st) && ph > 0 && dmem_addr !== w[7:0]) ctl_ok = 0;
      @(posedge clk); @(negedge clk);
    end
    model_exec();
    rq = req_for(w);
    check(ctl_ok, (ld || st) ? (ld ? "R6" : "R7") : "R11", "strobe timing",
          {32'h0, w}, {32'h0, w});
    ok = dbg_pc == m_pc && dbg_ir == m_ir && dbg_a == m_a && dbg_b == m_b
         && dbg_c == m_c && dbg_z == m_z;
    check(ok, rq, "state a/b", {dbg_a, dbg_b}, {m_a, m_b});
    check(ok, rq, "pc/ir/c/z", {dbg_pc, dbg_c, dbg_z, 24'h0, dbg_ir},
          {m_pc, m_c, m_z, 24'h0, m_ir});
    check(imem_addr == dbg_pc, "R2", "imem_addr", {58'h0, imem_addr}, {58'h0, dbg_pc});
    if (st) check(mem_d[w[7:0]] == m_dmem[w[7:0]], "R7", "stored word",
                  {32'h0, mem_d[w[7:0]]}, {32'h0, m_dmem[w[7:0]]});
  endtask

  task automatic check_reset();
    bit ok;
    ok = dbg_pc == 0 && dbg_ir == 0 && dbg_a == 0 && dbg_b == 0 && !dbg_c && !dbg_z
         && imem_addr == 0;
    check(ok, "R1", "reset state", {dbg_pc, dbg_c, dbg_z, 24'h0, dbg_a}, 64'h0);
  endtask

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 256; i++) begin
      mem_d[i] = $urandom(); m_dmem[i] = mem_d[i];
    end
    imem[0]  = mk(4'h1, 4'h2, 16'hFFFF);  // SETHI
    imem[1]  = mk(4'h7, 4'h3, 16'hFFFF);  // ORK -> all ones
    imem[2]  = mk(4'h7, 4'h5, 16'h0000);  // INC -> zero with carry
    imem[3]  = mk(4'h2, 4'h1, 16'h0006);  // BRZ taken
    imem[4]  = mk(4'h1, 4'h0, 16'h1234);
    imem[5]  = mk(4'h1, 4'h0, 16'h4321);
    imem[6]  = mk(4'h7, 4'h6, 16'h0000);  // DEC -> all ones, borrow
    imem[7]  = mk(4'h2, 4'h2, 16'h0009);  // BRNZ taken
    imem[8]  = mk(4'h1, 4'h3, 16'h0000);
    imem[9]  = {4'h1, 4'h1, 8'hA5, 16'h0005}; // SETB with junk bits
    imem[10] = mk(4'h0, 4'h3, 16'h01F3);  // STOREB
    imem[11] = mk(4'h1, 4'h4, 16'h0000);  // ZEROB
    imem[12] = mk(4'h0, 4'h1, 16'h00F3);  // LOADB
    imem[13] = mk(4'h7, 4'h1, 16'h0000);  // SUB
    imem[14] = mk(4'h7, 4'h7, 16'h0000);  // ROL
    imem[15] = mk(4'h7, 4'h8, 16'h0000);  // ROR
    imem[16] = mk(4'h3, 4'h0, 16'hFFFF);  // unlisted
    imem[17] = mk(4'h7, 4'h0, 16'h0000);  // ADD
    imem[18] = mk(4'h0, 4'h2, 16'h0010);  // STOREA
    imem[19] = mk(4'h2, 4'h0, 16'd20);    // JUMP
    for (int i = 20; i < 64; i++) begin
      logic [3:0] c;
      case ($urandom_range(0, 9))
        0, 1: c = 4'h0;
        2, 3: c = 4'h1;
        4:    c = 4'h2;
        5, 6, 7, 8: c = 4'h7;
        default: c = 4'($urandom_range(3, 15));
      endcase
      imem[i] = {c, 4'($urandom_range(0, 10)), 8'($urandom()), 16'($urandom())};
    end

    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset();
    rst = 1'b0;

    for (int n = 0; n < 17; n++) begin
      step(1'b0);
      if (n == 2) check(dbg_a == 0 && dbg_c && dbg_z, "R9", "INC wrap to zero",
                        {dbg_c, dbg_z, 30'h0, dbg_a}, {2'b11, 62'h0});
      if (n == 6) check(dbg_b == 32'h5, "R4", "ignored bits in SETB",
                        {32'h0, dbg_b}, 64'h5);
      if (n == 9) check(dbg_b == 32'h5, "R6", "load after clear",
                        {32'h0, dbg_b}, 64'h5);
    end
    for (int n = 0; n < 2500; n++) step(1'b1);

    en = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check_reset();
    rst = 1'b0;
    model_reset();
    for (int n = 0; n < 1500; n++) step(1'b1);

    summary();
  end

endmodule